// File: doc/BRIEF.md
# Saturating Digital Loopback Mixer

This block folds captured converter input back into the playback stream of a stereo audio path. Each of the two channels takes a signed 16-bit capture sample, a signed 16-bit playback sample delivered over the serial bus, and its own playback-enable flag. A shared mix-enable bit and a shared 6-bit attenuation code control the loopback path. The block produces a signed 16-bit sample for the output converter.

When mixing is on, the capture sample is scaled by the attenuation code and added to the playback sample. The playback sample is forced to zero when that channel's playback is off. The sum is formed one bit wider than the samples and then clamped to the 16-bit range, so it never wraps. The result is registered on a sample-valid strobe. Both channels share the control inputs but carry their own data, so each can be used as an independent stream.

Top module: `loopback_mixer`

## Requirements
- R1: While rst_ni is low, and after it is released until the first strobe, both DAC outputs read 0.
- R2: With mix_en_i low, a strobed channel outputs its playback sample if its playback enable is 1, and 0 otherwise.
- R3: With mix_en_i high, a strobed channel outputs clip(A + P), where A is the attenuated capture sample and P is the playback sample if its playback enable is 1, or 0 if it is not.
- R4: For an attenuation code c below all-ones (c < 63), A equals floor(x * m / 2^(6 + c/4)). Here x is the capture sample, c/4 is integer division, and m is 64, 54, 45 or 38 for c mod 4 = 0, 1, 2, 3. Each code step is about 1.5 dB, and |A| <= |x|.
- R5: The all-ones attenuation code (63) makes A equal to 0, so the output equals the gated playback sample.
- R6: A sum above +32767 gives +32767. Two non-negative operands never give a negative output.
- R7: A sum below -32768 gives -32768. Two negative operands never give a non-negative output.
- R8: The outputs change only at a rising clock edge where valid_i is 1, and take the new value in that same edge. When valid_i is low, they hold.
- R9: Left and right are computed independently. Each uses only its own capture sample, playback sample and playback enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; registers new outputs |
| mix_en_i | input | 1 | Enables the loopback path |
| atten_i | input | 6 | Loopback attenuation code, 1.5 dB per step, 63 = mute |
| adc_l_i | input | 16 | Left capture sample, signed |
| adc_r_i | input | 16 | Right capture sample, signed |
| play_l_i | input | 16 | Left playback sample, signed |
| play_r_i | input | 16 | Right playback sample, signed |
| play_en_l_i | input | 1 | Left playback enable |
| play_en_r_i | input | 1 | Right playback enable |
| dac_l_o | output | 16 | Left output sample, signed |
| dac_r_o | output | 16 | Right output sample, signed |

## Verification
The bench builds the block with its default 16-bit samples and 6-bit code. Every one of the 64 attenuation codes is then swept against extreme and mid-range capture values, several playback values, and all four mix/playback enable combinations. This covers each mantissa and shift of the gain law, the mute code, and both clip limits. The right channel receives different data and the opposite playback enable, which exposes any cross-channel coupling. Strobe-low cycles with changed inputs confirm that the outputs hold.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int unsigned GAIN_FRAC = 6;      // mantissa fraction bits
  localparam int unsigned STEP_LOG2 = 2;      // 4 steps of 1.5 dB per 6 dB

  typedef enum logic [1:0] {
    MANT_0DB0 = 2'd0,
    MANT_1DB5 = 2'd1,
    MANT_3DB0 = 2'd2,
    MANT_4DB5 = 2'd3
  } mant_sel_e;
endpackage

// File: rtl/mix_atten.sv
module mix_atten import mix_pkg::*; #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ATTEN_W  = 6
) (
  input  logic signed [SAMPLE_W-1:0] x_i,
  input  logic        [ATTEN_W-1:0]  code_i,
  output logic signed [SAMPLE_W-1:0] y_o
);
  localparam int unsigned PW = SAMPLE_W + GAIN_FRAC + 1;
  localparam int unsigned SW = ATTEN_W + 1;

  logic signed [PW-1:0] xe, prod, shifted;
  logic        [SW-1:0] shamt;
  mant_sel_e            sel;

  assign xe    = PW'(x_i);
  assign sel   = mant_sel_e'(code_i[STEP_LOG2-1:0]);
  assign shamt = SW'(GAIN_FRAC) + SW'(code_i >> STEP_LOG2);

  // exact mantissa product, shift-and-add only
  always_comb begin
    unique case (sel)
      MANT_0DB0: prod = xe <<< 6;                                    // 64
      MANT_1DB5: prod = (xe <<< 6) - (xe <<< 3) - (xe <<< 1);        // 54
      MANT_3DB0: prod = (xe <<< 5) + (xe <<< 3) + (xe <<< 2) + xe;   // 45
      default:   prod = (xe <<< 5) + (xe <<< 2) + (xe <<< 1);        // 38
    endcase
  end

  assign shifted = prod >>> shamt;
  assign y_o     = (code_i == '1) ? '0 : SAMPLE_W'(shifted);
endmodule

// File: rtl/mix_sat_add.sv
module mix_sat_add #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0] a_i,
  input  logic signed [SAMPLE_W-1:0] b_i,
  output logic signed [SAMPLE_W-1:0] s_o
);
  localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W:0] wide;

  assign wide = {a_i[SAMPLE_W-1], a_i} + {b_i[SAMPLE_W-1], b_i};

  always_comb begin
    unique case (wide[SAMPLE_W -: 2])
      2'b01:   s_o = MAX_V;
      2'b10:   s_o = MIN_V;
      default: s_o = wide[SAMPLE_W-1:0];
    endcase
  end
endmodule

// File: rtl/mix_channel.sv
module mix_channel #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ATTEN_W  = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       mix_en_i,
  input  logic        [ATTEN_W-1:0]  atten_i,
  input  logic signed [SAMPLE_W-1:0] adc_i,
  input  logic signed [SAMPLE_W-1:0] play_i,
  input  logic                       play_en_i,
  output logic signed [SAMPLE_W-1:0] dac_o
);
  logic signed [SAMPLE_W-1:0] att, loop_s, bus_s, mixed;

  mix_atten #(.SAMPLE_W(SAMPLE_W), .ATTEN_W(ATTEN_W)) u_atten (
    .x_i(adc_i), .code_i(atten_i), .y_o(att)
  );

  assign loop_s = mix_en_i  ? att    : '0;
  assign bus_s  = play_en_i ? play_i : '0;

  mix_sat_add #(.SAMPLE_W(SAMPLE_W)) u_add (
    .a_i(loop_s), .b_i(bus_s), .s_o(mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dac_o <= '0;
    else if (valid_i) dac_o <= mixed;
  end

  p_gain_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_i[SAMPLE_W-1] ? (att <= 0 && att >= adc_i) : (att >= 0 && att <= adc_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dac_o));

  p_mix_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mix_en_i |=> dac_o == $past(play_en_i ? play_i : '0));

  p_mute_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && atten_i == '1 |=> dac_o == $past(play_en_i ? play_i : '0));

  p_no_wrap_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !adc_i[SAMPLE_W-1] && !play_i[SAMPLE_W-1] |=> !dac_o[SAMPLE_W-1]);

  p_no_wrap_neg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mix_en_i && play_en_i && atten_i != '1 && adc_i[SAMPLE_W-1] &&
    play_i[SAMPLE_W-1] |=> dac_o[SAMPLE_W-1]);
endmodule

// File: rtl/loopback_mixer.sv
module loopback_mixer #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ATTEN_W  = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       mix_en_i,
  input  logic        [ATTEN_W-1:0]  atten_i,
  input  logic signed [SAMPLE_W-1:0] adc_l_i,
  input  logic signed [SAMPLE_W-1:0] adc_r_i,
  input  logic signed [SAMPLE_W-1:0] play_l_i,
  input  logic signed [SAMPLE_W-1:0] play_r_i,
  input  logic                       play_en_l_i,
  input  logic                       play_en_r_i,
  output logic signed [SAMPLE_W-1:0] dac_l_o,
  output logic signed [SAMPLE_W-1:0] dac_r_o
);
  localparam int unsigned NUM_CH = 2;

  logic [NUM_CH-1:0][SAMPLE_W-1:0] adc_v, play_v, dac_v;
  logic [NUM_CH-1:0]               pen_v;

  assign adc_v  = {adc_r_i, adc_l_i};
  assign play_v = {play_r_i, play_l_i};
  assign pen_v  = {play_en_r_i, play_en_l_i};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    mix_channel #(.SAMPLE_W(SAMPLE_W), .ATTEN_W(ATTEN_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .mix_en_i (mix_en_i),
      .atten_i  (atten_i),
      .adc_i    (adc_v[ch]),
      .play_i   (play_v[ch]),
      .play_en_i(pen_v[ch]),
      .dac_o    (dac_v[ch])
    );
  end

  assign dac_l_o = dac_v[0];
  assign dac_r_o = dac_v[1];

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (dac_l_o == '0 && dac_r_o == '0));
endmodule

// File: tb/loopback_mixer_bench.sv
`timescale 1ns/1ps
module loopback_mixer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, mix_en = 1'b0, pen_l = 1'b0, pen_r = 1'b0;
  logic [5:0] atten = '0;
  logic signed [15:0] adc_l = '0, adc_r = '0, play_l = '0, play_r = '0;
  logic signed [15:0] dac_l, dac_r;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  loopback_mixer u_loopback_mixer (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mix_en_i(mix_en), .atten_i(atten),
    .adc_l_i(adc_l), .adc_r_i(adc_r), .play_l_i(play_l), .play_r_i(play_r),
    .play_en_l_i(pen_l), .play_en_r_i(pen_r), .dac_l_o(dac_l), .dac_r_o(dac_r)
  );

  int adc_tab [8] = '{0, 1, -1, 32767, -32768, 20000, -20000, 300};
  int play_tab[6] = '{0, 32767, -32768, 15000, -15000, -1};

  function automatic int ref_att(int x, int c);
    longint p;
    int m;
    if (c == 63) return 0;
    case (c % 4)
      0: m = 64;
      1: m = 54;
      2: m = 45;
      default: m = 38;
    endcase
    p = longint'(x) * m;
    return int'(p >>> (6 + c / 4));
  endfunction

  function automatic int ref_dac(int x, int p, bit pe, bit me, int c);
    int s;
    s = (pe ? p : 0) + (me ? ref_att(x, c) : 0);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag(bit me, int c, int s);
    if (!me) return "R2";
    if (c == 63) return "R5";
    if (s == 32767) return "R6";
    if (s == -32768) return "R7";
    return (c % 4 == 0 && c == 0) ? "R3" : "R4";
  endfunction

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int el, er;
    repeat (3) @(negedge clk);
    check("R1 reset left", int'(dac_l), 0);
    check("R1 reset right", int'(dac_r), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(dac_l), 0);

    for (int c = 0; c < 64; c++) begin
      for (int md = 0; md < 4; md++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 6; j++) begin
            atten  = 6'(c);
            mix_en = md[1];
            pen_l  = md[0];
            pen_r  = !md[0];
            adc_l  = 16'(adc_tab[i]);
            adc_r  = 16'(adc_tab[7 - i]);
            play_l = 16'(play_tab[j]);
            play_r = 16'(play_tab[5 - j]);
            valid  = 1'b1;
            el = ref_dac(adc_tab[i], play_tab[j], md[0], md[1], c);
            er = ref_dac(adc_tab[7 - i], play_tab[5 - j], !md[0], md[1], c);
            @(negedge clk);
            valid = 1'b0;
            check({tag(md[1], c, el), " left"}, int'(dac_l), el);
            check({"R9 ", tag(md[1], c, er), " right"}, int'(dac_r), er);
          end
        end
      end
      // strobe low: change every input, outputs must hold (R8)
      adc_l = ~adc_l; adc_r = ~adc_r; play_l = ~play_l; play_r = ~play_r;
      pen_l = ~pen_l; pen_r = ~pen_r; mix_en = ~mix_en; atten = ~atten;
      @(negedge clk);
      check("R8 hold left", int'(dac_l), el);
      check("R8 hold right", int'(dac_r), er);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule